// File: doc/BRIEF.md
# Vacuum Fluorescent Display Grid Scanner

This block multiplexes a grid-and-anode vacuum fluorescent display. It keeps one anode pattern per grid in a small register bank. It turns on one grid at a time, and while that grid is on it drives the anode lines with the pattern stored for it. A host loads patterns through a simple write port: a grid index, a pattern word and a one-cycle write strobe. The high-voltage level translation, the filament drive and the character-to-segment decoding all sit outside the block.

The scan starts at the highest-numbered grid and counts down to grid 0, then wraps back to the top. Each grid stays lit for a fixed dwell of `DWELL_CYCLES` clock cycles. Between two grids there is exactly one blanking cycle in which every grid and anode line is low, so that the anodes set up for one grid never light segments under the next one.

Each grid's pattern is copied into the anode output register at the moment its dwell begins. A write that reaches the bank while a grid is lit therefore appears on the anodes from that grid's next dwell onward, and the anode lines never change in the middle of a dwell.

The scan is controlled by two states:
- `ST_BLANK`: one cycle with all outputs dark. Transition `T_SHOW` is always taken and goes to `ST_DWELL`; on that edge the current grid and its pattern are loaded into the output registers.
- `ST_DWELL`: the grid is lit. Transition `T_HOLD` keeps the state until the dwell timer expires. Transition `T_NEXT` then returns to `ST_BLANK`, clears the outputs and steps the grid index down by one, wrapping from 0 to the top grid.

Top module: `vfd_grid_scanner`

## Requirements
- R1: While reset is asserted (active low), `grid_o` and `anode_o` are all zero. Reset clears every stored pattern to zero. The first grid lit after reset is grid `NUM_GRIDS-1` (grid 10 with the defaults), shown with pattern zero.
- R2: At most one bit of `grid_o` is high in any cycle, where bit g enables grid g.
- R3: Grids light in descending index order, NUM_GRIDS-1, NUM_GRIDS-2, ..., 0, and the order then wraps to NUM_GRIDS-1.
- R4: Each grid stays lit for exactly `DWELL_CYCLES` consecutive cycles. After reset release, the first grid comes on at the first clock edge.
- R5: Between two lit grids there is exactly one cycle with `grid_o` and `anode_o` all zero. One grid never switches directly to another.
- R6: While grid g is lit, `anode_o` equals the pattern stored for grid g, where bit a drives anode line a. Whenever no grid is lit, `anode_o` is zero.
- R7: A write with `wr_en_i` high stores `wr_pattern_i` for grid `wr_grid_i` at the clock edge. The new pattern appears from the next dwell of that grid that starts after this edge. A write that lands on the same edge as that grid's dwell start, or during its dwell, leaves the current dwell unchanged.
- R8: A write whose index is `NUM_GRIDS` or more (11 to 15 with the defaults) is ignored and changes no stored pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the pattern bank |
| wr_grid_i | input | IDX_W (4) | Grid index of the pattern being written |
| wr_pattern_i | input | ANODE_W (14) | Anode pattern to store |
| grid_o | output | NUM_GRIDS (11) | One-hot grid enables, bit g is grid g |
| anode_o | output | ANODE_W (14) | Anode lines for the lit grid |

## Verification
The bench targets the wrap from grid 0 back to the top grid. A design that counts past zero would light nothing there, or would light an out-of-range grid. It rewrites a grid's pattern in the middle of its dwell and again on the very edge where its dwell starts. A design that reads the bank live, or that samples the pattern one edge late, would then change the anodes mid-dwell or show the new value too early. It also sends writes with indices 11 to 15 to catch aliasing onto real grids, and it checks every blanking cycle. A design that drops the gap, or stretches it to two cycles, would shift every later expected slot. Finally, a reset in the middle of a scan must clear the patterns and restart at grid 10.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    // Scan controller states
    typedef enum logic [0:0] {
        ST_BLANK = 1'b0,
        ST_DWELL = 1'b1
    } scan_state_e;

endpackage

// File: rtl/vfd_pattern_bank.sv
module vfd_pattern_bank #(
    parameter int NUM_GRIDS = 11,
    parameter int ANODE_W   = 14,
    parameter int IDX_W     = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [ANODE_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [ANODE_W-1:0] rd_data_o
);

    logic [ANODE_W-1:0] bank_q [NUM_GRIDS];

    // One register per grid; an index outside the bank hits no slot
    for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_slot
        logic slot_hit;
        assign slot_hit = wr_en_i && (wr_idx_i == IDX_W'(g));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                bank_q[g] <= '0;
            end else if (slot_hit) begin
                bank_q[g] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int g = 0; g < NUM_GRIDS; g++) begin
            if (rd_idx_i == IDX_W'(g)) begin
                rd_data_o = bank_q[g];
            end
        end
    end

endmodule

// File: rtl/vfd_dwell_timer.sv
module vfd_dwell_timer #(
    parameter int DWELL_CYCLES = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic done_o
);

    localparam int              CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || done_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/vfd_scan_fsm.sv
module vfd_scan_fsm
    import vfd_scan_pkg::*;
#(
    parameter int NUM_GRIDS = 11,
    parameter int IDX_W     = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dwell_done_i,
    output scan_state_e      state_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_GRIDS - 1);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // Next-state logic: T_SHOW, T_HOLD, T_NEXT
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_BLANK: begin
                state_d = ST_DWELL;                      // T_SHOW
            end
            ST_DWELL: begin
                if (dwell_done_i) begin                  // T_NEXT
                    state_d = ST_BLANK;
                    idx_d   = (idx_q == '0) ? TOP_IDX : idx_q - 1'b1;
                end                                      // else T_HOLD
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_BLANK;
            idx_q   <= TOP_IDX;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/vfd_grid_scanner.sv
module vfd_grid_scanner
    import vfd_scan_pkg::*;
#(
    parameter  int NUM_GRIDS    = 11,
    parameter  int ANODE_W      = 14,
    parameter  int DWELL_CYCLES = 6,
    localparam int IDX_W        = $clog2(NUM_GRIDS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_grid_i,
    input  logic [ANODE_W-1:0]   wr_pattern_i,
    output logic [NUM_GRIDS-1:0] grid_o,
    output logic [ANODE_W-1:0]   anode_o
);

    scan_state_e          scan_state;
    logic [IDX_W-1:0]     scan_idx;
    logic                 dwell_done;
    logic [ANODE_W-1:0]   rd_pattern;
    logic [NUM_GRIDS-1:0] grid_sel;
    logic [NUM_GRIDS-1:0] grid_q;
    logic [ANODE_W-1:0]   anode_q;

    vfd_pattern_bank #(
        .NUM_GRIDS (NUM_GRIDS),
        .ANODE_W   (ANODE_W),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_grid_i),
        .wr_data_i (wr_pattern_i),
        .rd_idx_i  (scan_idx),
        .rd_data_o (rd_pattern)
    );

    vfd_dwell_timer #(
        .DWELL_CYCLES (DWELL_CYCLES)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (scan_state == ST_DWELL),
        .done_o (dwell_done)
    );

    vfd_scan_fsm #(
        .NUM_GRIDS (NUM_GRIDS),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .dwell_done_i (dwell_done),
        .state_o      (scan_state),
        .idx_o        (scan_idx)
    );

    // Grid index decoder
    for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_dec
        assign grid_sel[g] = (scan_idx == IDX_W'(g));
    end

    // Output process: load at dwell start, clear when the dwell ends
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            grid_q  <= '0;
            anode_q <= '0;
        end else begin
            unique case (scan_state)
                ST_BLANK: begin
                    grid_q  <= grid_sel;
                    anode_q <= rd_pattern;
                end
                ST_DWELL: begin
                    if (dwell_done) begin
                        grid_q  <= '0;
                        anode_q <= '0;
                    end
                end
            endcase
        end
    end

    assign grid_o  = grid_q;
    assign anode_o = anode_q;

endmodule

// File: rtl/vfd_grid_scanner_chk.sv
module vfd_grid_scanner_chk #(
    parameter int NUM_GRIDS    = 11,
    parameter int ANODE_W      = 14,
    parameter int DWELL_CYCLES = 6
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_GRIDS-1:0] grid_o,
    input logic [ANODE_W-1:0]   anode_o
);

    localparam logic [NUM_GRIDS-1:0] TOP_VEC = {1'b1, {(NUM_GRIDS-1){1'b0}}};

    logic                 prev_active;
    logic                 seen;
    logic [NUM_GRIDS-1:0] last_vec;
    int                   run_cnt;
    logic                 active;
    logic                 onset;
    logic [NUM_GRIDS-1:0] exp_next;

    assign active   = |grid_o;
    assign onset    = active && !prev_active;
    assign exp_next = (!seen || last_vec[0]) ? TOP_VEC : (last_vec >> 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_active <= 1'b0;
            seen        <= 1'b0;
            last_vec    <= '0;
            run_cnt     <= 0;
        end else begin
            prev_active <= active;
            run_cnt     <= active ? run_cnt + 1 : 0;
            if (active) begin
                seen     <= 1'b1;
                last_vec <= grid_o;
            end
        end
    end

    // R1
    reset_dark_chk: assert property (@(posedge clk_i)
        !rst_ni |-> (grid_o == '0 && anode_o == '0));

    // R2
    one_grid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grid_o));

    // R3
    scan_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        onset |-> grid_o == exp_next);

    // R4
    dwell_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_active && !active) |-> run_cnt == DWELL_CYCLES);

    // R4
    dwell_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active |-> run_cnt < DWELL_CYCLES);

    // R5
    blank_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_active && !active) |=> active);

    // R5
    no_direct_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_active && active) |-> grid_o == last_vec);

    // R6
    dark_anode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active |-> anode_o == '0);

    // R7
    anode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_active && active) |-> $stable(anode_o));

endmodule

bind vfd_grid_scanner vfd_grid_scanner_chk #(
    .NUM_GRIDS    (NUM_GRIDS),
    .ANODE_W      (ANODE_W),
    .DWELL_CYCLES (DWELL_CYCLES)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .grid_o  (grid_o),
    .anode_o (anode_o)
);

// File: tb/vfd_grid_scanner_bench.sv
module vfd_grid_scanner_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NG   = 11;
    localparam int AW   = 14;
    localparam int DW   = 4;
    localparam int IW   = 4;
    localparam int SLOT = DW + 1;
    localparam int FRAME = SLOT * NG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_grid = '0;
    logic [AW-1:0] wr_pat = '0;
    logic [NG-1:0] grid_o;
    logic [AW-1:0] anode_o;

    typedef struct {
        int            grid;
        logic [AW-1:0] pat;
    } item_t;

    item_t         exp_q[$];
    logic [AW-1:0] model [NG];
    int            checks = 0;
    int            errors = 0;
    int            cyc = 0;
    bit            finished = 1'b0;

    vfd_grid_scanner #(
        .NUM_GRIDS    (NG),
        .ANODE_W      (AW),
        .DWELL_CYCLES (DW)
    ) u_vfd_grid_scanner (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_grid_i    (wr_grid),
        .wr_pattern_i (wr_pat),
        .grid_o       (grid_o),
        .anode_o      (anode_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] pat_of(int g);
        return AW'((g * 1237 + 91) ^ (g << 9));
    endfunction

    task automatic write_pat(int g, logic [AW-1:0] p, bit sync_neg);
        if (sync_neg) @(negedge clk);
        wr_en   = 1'b1;
        wr_grid = IW'(g);
        wr_pat  = p;
        @(posedge clk);
        #1;
        if (g < NG) model[g] = p;   // R8: out-of-range writes leave the model alone
        wr_en = 1'b0;
    endtask

    // Predictor: push one expected item at every dwell start edge (R3, R4, R7)
    always @(posedge clk) begin
        int    slot;
        item_t it;
        if (!rst_n) begin
            cyc = 0;
            exp_q.delete();
        end else begin
            cyc++;
            if (cyc % SLOT == 1) begin
                slot    = (cyc - 1) / SLOT;
                it.grid = NG - 1 - (slot % NG);
                it.pat  = model[it.grid];
                exp_q.push_back(it);
            end
        end
    end

    // Monitor: compare outputs against the queue between edges
    always @(negedge clk) begin
        int            ph;
        item_t         it;
        logic [NG-1:0] ev;
        if (rst_n) begin
            ph = cyc % SLOT;
            if (ph == 0) begin
                chk(grid_o == '0 && anode_o == '0, "R5", "blank gap",
                    {grid_o, anode_o}, 32'h0);
            end else if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "no expected item", 32'(grid_o), 32'h0);
            end else begin
                it = exp_q[0];
                ev = '0;
                ev[it.grid] = 1'b1;
                chk(grid_o == ev, "R2 R3 R4", "grid vector", 32'(grid_o), 32'(ev));
                chk(anode_o == it.pat, "R6 R7 R8", "anode pattern", 32'(anode_o), 32'(it.pat));
                if (ph == DW) void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        for (int i = 0; i < NG; i++) model[i] = '0;
        #1 rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(grid_o == '0 && anode_o == '0, "R1", "outputs in reset", {grid_o, anode_o}, 32'h0);
        end
        @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: first frame after reset shows cleared patterns from grid 10 down
        repeat (FRAME) @(posedge clk);

        // R6: load distinct patterns while scanning
        for (int g = 0; g < NG; g++) write_pat(g, pat_of(g), 1'b1);
        repeat (2 * FRAME) @(posedge clk);

        // R7: write to the lit grid in the middle of its dwell
        do @(negedge clk); while (!grid_o[5]);
        write_pat(5, 14'h3C3C, 1'b1);

        // R7: write landing on the exact edge where grid 2's dwell starts
        do @(negedge clk); while (!grid_o[3]);
        do @(negedge clk); while (grid_o != '0);
        write_pat(2, 14'h1111, 1'b0);
        repeat (2 * FRAME) @(posedge clk);

        // R8: out-of-range indices must not alias onto real grids
        for (int g = NG; g < 16; g++) write_pat(g, 14'h3FFF, 1'b1);
        repeat (2 * FRAME) @(posedge clk);

        // R1: reset in the middle of a scan
        do @(negedge clk); while (!grid_o[7]);
        @(posedge clk);
        #2 rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(grid_o == '0 && anode_o == '0, "R1", "outputs in mid-run reset", {grid_o, anode_o}, 32'h0);
        end
        for (int i = 0; i < NG; i++) model[i] = '0;
        @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (FRAME + 3) @(posedge clk);

        @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule